// File: doc/BRIEF.md
# Floating-Point Status Flag Controller

This block keeps the floating-point portion of a user status register around each arithmetic operation. It holds a two-bit rounding-mode field and decodes it into a one-hot select for the arithmetic unit. It also holds a set of five exception-enable bits and five sticky exception flags. While an operation runs, raw exception indications from the arithmetic unit are collected in a per-operation accumulator. That accumulator is emptied when an operation starts.

When the operation ends, the collected indications are merged into the sticky flags. A flag that goes from clear to set while its enable bit is on raises a one-cycle trap request. The request carries the vector of newly set, enabled causes and the index of the first cause in the fixed processing order. A flag that is already set never requests a trap again. Software changes the register only through a full-register write, and that write wins over a merge in the same cycle. The arithmetic itself lies outside this block.

Flag index order, used in every flag vector: bit 0 inexact, bit 1 divide-by-zero, bit 2 invalid, bit 3 overflow, bit 4 underflow. Register write layout: `wr_data[1:0]` rounding field, `wr_data[6:2]` enable bits, `wr_data[11:7]` sticky flags.

Top module: `fp_status_ctrl`

## Requirements
- R1: After synchronous active-low reset, sticky flags and enables are 0, the rounding field is 0 (one-hot select 4'b0001) and no trap is requested.
- R2: The rounding field decodes as 0 nearest-even (select bit 0), 1 toward zero (bit 1), 2 toward minus infinity (bit 2), 3 toward plus infinity (bit 3); exactly one select bit is high.
- R3: A register write with wr_en loads the rounding field from wr_data[1:0], enables from wr_data[6:2] and sticky flags from wr_data[11:7]; the new values are visible the cycle after the write.
- R4: op_start empties the accumulator, so raw flags seen before the op_start cycle do not reach the sticky flags; raw flags in the op_start cycle are kept.
- R5: Raw flags arriving in any cycle up to and including the op_end cycle are OR-accumulated and merged at op_end.
- R6: At op_end each merged flag sets its sticky bit; sticky bits are never cleared except by a register write, and an op_end with no merged flag leaves them unchanged.
- R7: In the cycle after op_end, trap_req is high for one cycle exactly when some flag went from clear to set with its enable bit at 1; trap_cause holds those flags (bit order as above).
- R8: A flag whose sticky bit is already set causes no trap and does not appear in trap_cause.
- R9: trap_code gives the lowest set index of trap_cause, the processing order being inexact (0), divide-by-zero (1), invalid (2), overflow (3), underflow (4).
- R10: A register write in the same cycle as op_end takes priority: the written sticky value is kept, the merge is dropped and no trap is requested.
- R11: op_end empties the accumulator, so a later op_end with no new raw flags changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Floating-point operation begins (empties accumulator) |
| op_end | input | 1 | Floating-point operation completes (merge into sticky flags) |
| raw_flags | input | 5 | Raw exception indications from the arithmetic unit |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 12 | Register write value (rounding, enables, sticky) |
| sticky_flags | output | 5 | Sticky exception flags |
| rnd_mode | output | 2 | Current rounding-mode field |
| rnd_onehot | output | 4 | Decoded one-hot rounding select |
| trap_req | output | 1 | One-cycle exception request |
| trap_cause | output | 5 | Newly set, enabled flags behind the request |
| trap_code | output | 3 | Index of the first cause in processing order |

## Verification
The merge is tried with flags that arrive before op_start, in the middle of an operation and in the op_end cycle. These separate a correctly emptied accumulator from one that leaks, and a merge that samples only the last cycle from one that collects every cycle. Trap patterns mix enabled and disabled flags and repeat flags that are already sticky. They also raise several causes at once with different lowest indices, which tells a clear-to-set trigger from a level trigger and checks the priority order. Writes coinciding with op_end, and an op_end with nothing raised, check the write priority and the no-update case.

// File: rtl/fpsc_pkg.sv
// Package: shared defaults and encodings for the floating-point status
// flag controller. Assumes flag vectors are indexed by flag_idx_e.
package fpsc_pkg;

    localparam int FLAGS_DEF = 5;  // number of exception flags
    localparam int RND_W_DEF = 2;  // width of rounding-mode field

    // Flag bit positions; the numeric order is also the processing order.
    typedef enum int {
        FLG_INEXACT   = 0,
        FLG_DIVZERO   = 1,
        FLG_INVALID   = 2,
        FLG_OVERFLOW  = 3,
        FLG_UNDERFLOW = 4
    } flag_idx_e;

    // Rounding-mode field values.
    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_TO_ZERO   = 2'd1,
        RND_TO_NEGINF = 2'd2,
        RND_TO_POSINF = 2'd3
    } rnd_mode_e;

endpackage

// File: rtl/fpsc_round_dec.sv
// Module: rounding-mode holder and decoder.
// Holds the rounding field, loaded by a register write, and decodes it into
// a one-hot select for the arithmetic unit. Assumes a synchronous
// active-low reset that returns the field to nearest-even.
module fpsc_round_dec #(
    parameter int RND_W = fpsc_pkg::RND_W_DEF,
    localparam int NUM_MODES = 1 << RND_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RND_W-1:0]     wr_field,
    output logic [RND_W-1:0]     rnd_mode,
    output logic [NUM_MODES-1:0] rnd_onehot
);

    logic [RND_W-1:0] rnd_q;

    // Field register: reset to nearest-even, load on software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd_q <= RND_W'(fpsc_pkg::RND_NEAR_EVEN);
        end else if (wr_en) begin
            rnd_q <= wr_field;
        end
    end

    assign rnd_mode = rnd_q;

    // One select line per encodable mode.
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_dec
        assign rnd_onehot[g] = (rnd_q == RND_W'(g));
    end

endmodule

// File: rtl/fpsc_accum.sv
// Module: per-operation exception accumulator.
// ORs raw flags cycle by cycle. op_start discards what was gathered before
// it (the op_start cycle's own flags are kept); op_end empties it after the
// merged value has been handed on. Assumes op_start/op_end are one-cycle strobes.
module fpsc_accum #(
    parameter int NUM_FLAGS = fpsc_pkg::FLAGS_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_start,
    input  logic                 op_end,
    input  logic [NUM_FLAGS-1:0] raw_flags,
    output logic [NUM_FLAGS-1:0] merged
);

    logic [NUM_FLAGS-1:0] acc_q;
    logic [NUM_FLAGS-1:0] base;

    // Merged view: history (unless restarted) plus this cycle's flags.
    always_comb begin
        base   = op_start ? '0 : acc_q;
        merged = base | raw_flags;
    end

    // Accumulator register: empty on reset and after op_end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (op_end) begin
            acc_q <= '0;
        end else begin
            acc_q <= merged;
        end
    end

endmodule

// File: rtl/fpsc_sticky.sv
// Module: sticky flag and trap request logic.
// At op_end, merged flags set their sticky bits; only bits going from clear
// to set with their enable on become trap causes. A register write in the
// same cycle wins and suppresses the merge. Trap outputs are registered and
// last one cycle. Assumes NUM_FLAGS fits in CODE_W bits.
module fpsc_sticky #(
    parameter int NUM_FLAGS = fpsc_pkg::FLAGS_DEF,
    localparam int CODE_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_end,
    input  logic                 wr_en,
    input  logic [NUM_FLAGS-1:0] wr_sticky,
    input  logic [NUM_FLAGS-1:0] wr_enable,
    input  logic [NUM_FLAGS-1:0] merged,
    output logic [NUM_FLAGS-1:0] sticky,
    output logic [NUM_FLAGS-1:0] enables,
    output logic                 trap_req,
    output logic [NUM_FLAGS-1:0] trap_cause,
    output logic [CODE_W-1:0]    trap_code
);

    logic [NUM_FLAGS-1:0] newly_set;
    logic [NUM_FLAGS-1:0] new_cause;

    // Lowest set index wins: inexact is processed first.
    function automatic logic [CODE_W-1:0] first_set(input logic [NUM_FLAGS-1:0] v);
        logic [CODE_W-1:0] idx;
        idx = '0;
        for (int i = NUM_FLAGS - 1; i >= 0; i--) begin
            if (v[i]) idx = CODE_W'(i);
        end
        return idx;
    endfunction

    // Clear-to-set detection and enable masking.
    always_comb begin
        newly_set = merged & ~sticky;
        new_cause = newly_set & enables;
    end

    // Sticky, enable and trap registers; write beats merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky     <= '0;
            enables    <= '0;
            trap_req   <= 1'b0;
            trap_cause <= '0;
            trap_code  <= '0;
        end else if (wr_en) begin
            sticky     <= wr_sticky;
            enables    <= wr_enable;
            trap_req   <= 1'b0;
            trap_cause <= '0;
            trap_code  <= '0;
        end else if (op_end) begin
            sticky     <= sticky | newly_set;
            trap_req   <= |new_cause;
            trap_cause <= new_cause;
            trap_code  <= first_set(new_cause);
        end else begin
            trap_req   <= 1'b0;
            trap_cause <= '0;
            trap_code  <= '0;
        end
    end

endmodule

// File: rtl/fp_status_ctrl.sv
// Module: floating-point status flag controller (top).
// Splits the register write into rounding, enable and sticky fields and
// wires the rounding decoder, the accumulator and the sticky/trap logic.
// Assumes write layout {sticky, enables, rounding} from MSB to LSB.
module fp_status_ctrl #(
    parameter int NUM_FLAGS = fpsc_pkg::FLAGS_DEF,
    parameter int RND_W     = fpsc_pkg::RND_W_DEF,
    localparam int NUM_MODES = 1 << RND_W,
    localparam int CODE_W    = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1,
    localparam int EN_LSB    = RND_W,
    localparam int STK_LSB   = RND_W + NUM_FLAGS,
    localparam int REG_W     = RND_W + 2 * NUM_FLAGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_start,
    input  logic                 op_end,
    input  logic [NUM_FLAGS-1:0] raw_flags,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [NUM_FLAGS-1:0] sticky_flags,
    output logic [RND_W-1:0]     rnd_mode,
    output logic [NUM_MODES-1:0] rnd_onehot,
    output logic                 trap_req,
    output logic [NUM_FLAGS-1:0] trap_cause,
    output logic [CODE_W-1:0]    trap_code
);

    logic [NUM_FLAGS-1:0] merged_flags;
    logic [NUM_FLAGS-1:0] flag_enables;

    fpsc_round_dec #(.RND_W(RND_W)) u_round (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_field   (wr_data[RND_W-1:0]),
        .rnd_mode   (rnd_mode),
        .rnd_onehot (rnd_onehot)
    );

    fpsc_accum #(.NUM_FLAGS(NUM_FLAGS)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .op_end    (op_end),
        .raw_flags (raw_flags),
        .merged    (merged_flags)
    );

    fpsc_sticky #(.NUM_FLAGS(NUM_FLAGS)) u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_end     (op_end),
        .wr_en      (wr_en),
        .wr_sticky  (wr_data[STK_LSB +: NUM_FLAGS]),
        .wr_enable  (wr_data[EN_LSB +: NUM_FLAGS]),
        .merged     (merged_flags),
        .sticky     (sticky_flags),
        .enables    (flag_enables),
        .trap_req   (trap_req),
        .trap_cause (trap_cause),
        .trap_code  (trap_code)
    );

endmodule

// File: rtl/fpsc_checker.sv
// Module: assertion checker for fp_status_ctrl, attached by bind below.
// Assumes the same parameter values and field layout as the top.
module fpsc_checker #(
    parameter int NUM_FLAGS = fpsc_pkg::FLAGS_DEF,
    parameter int RND_W     = fpsc_pkg::RND_W_DEF,
    localparam int NUM_MODES = 1 << RND_W,
    localparam int CODE_W    = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1,
    localparam int EN_LSB    = RND_W,
    localparam int STK_LSB   = RND_W + NUM_FLAGS,
    localparam int REG_W     = RND_W + 2 * NUM_FLAGS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_end,
    input logic                 wr_en,
    input logic [REG_W-1:0]     wr_data,
    input logic [NUM_FLAGS-1:0] sticky_flags,
    input logic [NUM_FLAGS-1:0] flag_enables,
    input logic [RND_W-1:0]     rnd_mode,
    input logic [NUM_MODES-1:0] rnd_onehot,
    input logic                 trap_req,
    input logic [NUM_FLAGS-1:0] trap_cause,
    input logic [CODE_W-1:0]    trap_code
);

    assert_onehot_round_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rnd_onehot) == 1);

    assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rnd_mode == $past(wr_data[RND_W-1:0]))
              && (flag_enables == $past(wr_data[EN_LSB +: NUM_FLAGS]))
              && (sticky_flags == $past(wr_data[STK_LSB +: NUM_FLAGS])));

    assert_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((sticky_flags & $past(sticky_flags)) == $past(sticky_flags)));

    assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !op_end) |=> $stable(sticky_flags));

    assert_trap_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($past(op_end) && !$past(wr_en)));

    assert_cause_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((trap_cause & ~flag_enables) == '0) && ((trap_cause & ~sticky_flags) == '0));

    assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((trap_cause & $past(sticky_flags)) == '0));

    assert_code_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_cause[trap_code]
                 && ((trap_cause & ((NUM_FLAGS'(1) << trap_code) - NUM_FLAGS'(1))) == '0));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_end) |=> !trap_req);

endmodule

bind fp_status_ctrl fpsc_checker #(.NUM_FLAGS(NUM_FLAGS), .RND_W(RND_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_end       (op_end),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .sticky_flags (sticky_flags),
    .flag_enables (flag_enables),
    .rnd_mode     (rnd_mode),
    .rnd_onehot   (rnd_onehot),
    .trap_req     (trap_req),
    .trap_cause   (trap_cause),
    .trap_code    (trap_code)
);

// File: tb/sim_fp_status_ctrl.sv
// Directed bench for fp_status_ctrl: one task per scenario, each checking
// its own results. Inputs change 1 ns after a rising edge; outputs are
// sampled at that same point, after the edge that registers them.
module sim_fp_status_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic       op_end = 1'b0;
    logic [4:0] raw_flags = '0;
    logic       wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [4:0] sticky_flags;
    logic [1:0] rnd_mode;
    logic [3:0] rnd_onehot;
    logic       trap_req;
    logic [4:0] trap_cause;
    logic [2:0] trap_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fp_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_end(op_end),
        .raw_flags(raw_flags), .wr_en(wr_en), .wr_data(wr_data),
        .sticky_flags(sticky_flags), .rnd_mode(rnd_mode), .rnd_onehot(rnd_onehot),
        .trap_req(trap_req), .trap_cause(trap_cause), .trap_code(trap_code)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] stk, input logic [4:0] en, input logic [1:0] rnd);
        wr_en = 1'b1;
        wr_data = {stk, en, rnd};
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    // Single-cycle operation: start and end together.
    task automatic quick_op(input logic [4:0] raw);
        op_start = 1'b1;
        op_end = 1'b1;
        raw_flags = raw;
        tick();
        op_start = 1'b0;
        op_end = 1'b0;
        raw_flags = '0;
    endtask

    task automatic t_reset();
        chk("R1", "sticky", 32'(sticky_flags), 32'h0);
        chk("R1", "rnd_mode", 32'(rnd_mode), 32'h0);
        chk("R1", "rnd_onehot", 32'(rnd_onehot), 32'h1);
        chk("R1", "trap_req", 32'(trap_req), 32'h0);
    endtask

    task automatic t_round();
        for (int r = 0; r < 4; r++) begin
            do_write(5'b0, 5'b0, 2'(r));
            chk("R2", "rnd_onehot", 32'(rnd_onehot), 32'(1) << r);
            chk("R3", "rnd_mode", 32'(rnd_mode), 32'(r));
        end
    endtask

    task automatic t_write();
        do_write(5'b10101, 5'b0, 2'd0);
        chk("R3", "sticky load", 32'(sticky_flags), 32'h15);
        do_write(5'b0, 5'b0, 2'd0);
        chk("R3", "sticky clear", 32'(sticky_flags), 32'h0);
    endtask

    // Pre-start flag dropped; mid and end flags kept; enables off.
    task automatic t_accum();
        raw_flags = 5'b00100;           // invalid, before start
        tick();
        op_start = 1'b1; raw_flags = 5'b0;
        tick();
        op_start = 1'b0; raw_flags = 5'b01000;  // overflow mid-op
        tick();
        raw_flags = 5'b0;
        tick();
        op_end = 1'b1; raw_flags = 5'b10000;    // underflow on op_end
        tick();
        op_end = 1'b0; raw_flags = 5'b0;
        chk("R4", "pre-start flag excluded", 32'(sticky_flags & 5'b00100), 32'h0);
        chk("R5", "accumulated sticky", 32'(sticky_flags), 32'h18);
        chk("R7", "no trap when disabled", 32'(trap_req), 32'h0);
        // Flag raised in the op_start cycle itself is kept.
        do_write(5'b0, 5'b0, 2'd0);
        op_start = 1'b1; raw_flags = 5'b00001;
        tick();
        op_start = 1'b0; raw_flags = 5'b0; op_end = 1'b1;
        tick();
        op_end = 1'b0;
        chk("R4", "start-cycle flag kept", 32'(sticky_flags), 32'h1);
    endtask

    task automatic t_noflag();
        do_write(5'b10001, 5'b11111, 2'd0);
        quick_op(5'b0);
        chk("R6", "no-flag op unchanged", 32'(sticky_flags), 32'h11);
        chk("R6", "no-flag no trap", 32'(trap_req), 32'h0);
        quick_op(5'b00010);
        chk("R6", "op sets without clearing", 32'(sticky_flags), 32'h13);
    endtask

    task automatic t_trap();
        do_write(5'b0, 5'b11111, 2'd0);
        op_start = 1'b1;
        tick();
        op_start = 1'b0; op_end = 1'b1; raw_flags = 5'b01010;
        tick();
        op_end = 1'b0; raw_flags = 5'b0;
        chk("R6", "sticky after op", 32'(sticky_flags), 32'h0a);
        chk("R7", "trap_req", 32'(trap_req), 32'h1);
        chk("R7", "trap_cause", 32'(trap_cause), 32'h0a);
        chk("R9", "trap_code divzero", 32'(trap_code), 32'h1);
        tick();
        chk("R7", "trap pulse ends", 32'(trap_req), 32'h0);
    endtask

    task automatic t_retrig();
        quick_op(5'b00010);
        chk("R8", "set flag no trap", 32'(trap_req), 32'h0);
        chk("R8", "sticky unchanged", 32'(sticky_flags), 32'h0a);
        quick_op(5'b10010);
        chk("R8", "only new cause", 32'(trap_cause), 32'h10);
        chk("R8", "trap_req new", 32'(trap_req), 32'h1);
        chk("R9", "trap_code underflow", 32'(trap_code), 32'h4);
    endtask

    task automatic t_mask_order();
        do_write(5'b0, 5'b00100, 2'd0);
        quick_op(5'b00101);
        chk("R6", "both set", 32'(sticky_flags), 32'h05);
        chk("R7", "masked cause", 32'(trap_cause), 32'h04);
        chk("R9", "trap_code invalid", 32'(trap_code), 32'h2);
        do_write(5'b0, 5'b11111, 2'd0);
        quick_op(5'b11000);
        chk("R9", "trap_code overflow", 32'(trap_code), 32'h3);
        do_write(5'b0, 5'b11111, 2'd0);
        quick_op(5'b11111);
        chk("R9", "trap_code inexact", 32'(trap_code), 32'h0);
        chk("R7", "all causes", 32'(trap_cause), 32'h1f);
    endtask

    task automatic t_wr_prio();
        do_write(5'b0, 5'b11111, 2'd0);
        op_start = 1'b1;
        tick();
        op_start = 1'b0; op_end = 1'b1; raw_flags = 5'b00001;
        wr_en = 1'b1; wr_data = {5'b00000, 5'b11111, 2'd1};
        tick();
        op_end = 1'b0; raw_flags = 5'b0; wr_en = 1'b0; wr_data = '0;
        chk("R10", "write wins sticky", 32'(sticky_flags), 32'h0);
        chk("R10", "no trap", 32'(trap_req), 32'h0);
        chk("R10", "rnd written", 32'(rnd_mode), 32'h1);
    endtask

    task automatic t_acc_clear();
        do_write(5'b0, 5'b11111, 2'd0);
        op_start = 1'b1; raw_flags = 5'b00100;
        tick();
        op_start = 1'b0; raw_flags = 5'b0; op_end = 1'b1;
        tick();
        op_end = 1'b0;
        chk("R11", "first end sets", 32'(sticky_flags), 32'h04);
        do_write(5'b0, 5'b11111, 2'd0);
        op_end = 1'b1;
        tick();
        op_end = 1'b0;
        chk("R11", "second end nothing", 32'(sticky_flags), 32'h0);
        chk("R11", "second end no trap", 32'(trap_req), 32'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_round();
        t_write();
        t_accum();
        t_noflag();
        t_trap();
        t_retrig();
        t_mask_order();
        t_wr_prio();
        t_acc_clear();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule